// File: doc/BRIEF.md
# Shared Endpoint Buffer Allocator

This block divides one 8 KB packet memory among sixteen endpoints: two control endpoints and fourteen data endpoints. Software stages a setting for each data endpoint: an enable, a transfer type, a maximum packet size and a double-buffer option. A commit strobe then turns the staged settings into a layout. The control endpoints come first, each with a fixed single 64-byte region. The data endpoints follow in index order. Each enabled data endpoint takes a region of its packet size, rounded up to a multiple of 4 bytes, or two such regions when it is double buffered. A disabled endpoint takes nothing.

After the commit the block keeps a full flag for every buffer half. It gives a producer side (USB engine) and a consumer side (processor) each its own endpoint select, completion strobe, readiness output and byte pointer into the memory. The USB side fills the half it points at and the processor side drains the half it points at. With double buffering each side moves on to the other half after every accepted strobe, so the two sides can work on different halves at the same time.

Top module: `ep_buf_alloc`

## Requirements
- R1: After reset and before the first commit, usb_ready, cpu_avail and alloc_err are 0 for every endpoint, and done strobes have no effect.
- R2: Endpoints 0 and 1 always receive single 64-byte regions at byte offsets 0 and 64. Configuration writes addressed to them are ignored.
- R3: Data endpoints 2..15 are placed contiguously from byte 128 upward in increasing index order. An enabled endpoint takes one rounded region, or two if double buffered. A disabled endpoint takes no space and its usb_ready and cpu_avail stay 0.
- R4: The packet size is rounded up to the next multiple of 4 bytes before placement; for example, size 10 takes 12 bytes per half.
- R5: alloc_err becomes 1 after a commit whose total exceeds 8192 bytes. A total of exactly 8192 bytes is accepted. While alloc_err is 1, usb_ready and cpu_avail are 0 and strobes are ignored.
- R6: A usb_done strobe on an endpoint with usb_ready=1 marks the current producer half full. For a single-buffered endpoint, usb_ready then reads 0 and cpu_avail reads 1 from the next cycle on.
- R7: For a double-buffered endpoint, an accepted usb_done moves the producer half to the other half, so usb_ptr alternates between base and base+rounded size. usb_ready stays 1 until both halves are full.
- R8: A cpu_done strobe on an endpoint with cpu_avail=1 empties the current consumer half. For a double-buffered endpoint it then moves to the other half; cpu_ptr follows the same rule as usb_ptr.
- R9: usb_done while usb_ready=0, and cpu_done while cpu_avail=0, change no state.
- R10: Staged writes take effect only at a commit. The new layout is visible from the cycle after the commit. A commit empties all halves and returns both sides to half 0, and it overrides any strobe in the same cycle.
- R11: usb_type reports the committed type of the endpoint selected by usb_ep. Control endpoints report 0.
- R12: usb_done and cpu_done in the same cycle, on the same double-buffered endpoint or on different endpoints, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Stage the setting below for endpoint cfg_ep |
| cfg_ep | input | 4 | Endpoint addressed by the staging write |
| cfg_en | input | 1 | Staged enable |
| cfg_dbl | input | 1 | Staged double-buffer option |
| cfg_type | input | 2 | Staged transfer type (opaque code) |
| cfg_size | input | 11 | Staged maximum packet size in bytes |
| commit | input | 1 | Recompute the layout from the staged settings |
| usb_ep | input | 4 | Endpoint selected by the USB side |
| usb_done | input | 1 | USB side finished filling its current half |
| cpu_ep | input | 4 | Endpoint selected by the processor side |
| cpu_done | input | 1 | Processor side finished draining its current half |
| usb_ptr | output | 13 | Byte address of the USB side's current half |
| usb_ready | output | 1 | USB side's current half is empty and usable |
| usb_type | output | 2 | Committed type of usb_ep |
| cpu_ptr | output | 13 | Byte address of the processor side's current half |
| cpu_avail | output | 1 | Processor side's current half is full |
| alloc_err | output | 1 | Last committed layout exceeds the memory |

## Verification
A fill and a drain can land in the same cycle. On one double-buffered endpoint they act on different halves and must not disturb each other's flags or half pointers. The bench provokes this directly: it fills one half and then strobes usb_done and cpu_done together on that endpoint. In the random phase it also sets cpu_ep equal to usb_ep in about half of the cycles, with random strobes and an occasional commit in the same cycle. A model in the bench updates the producer and consumer effects separately from the state before the edge. Pointers, readiness and flags are compared with that model every cycle.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
    localparam int NUM_EP     = 16;
    localparam int NUM_CTRL   = 2;
    localparam int MEM_BYTES  = 8192;
    localparam int CTRL_BYTES = 64;
    localparam int SIZE_W     = 11;
    localparam int TYPE_W     = 2;

    localparam int EP_W   = $clog2(NUM_EP);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int RSZ_W  = SIZE_W + 1;
    localparam int SUM_W  = RSZ_W + 1 + EP_W;

    typedef struct packed {
        logic              en;
        logic              dbl;
        logic [TYPE_W-1:0] typ;
        logic [SIZE_W-1:0] size;
    } ep_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [RSZ_W-1:0]  rsz;
        logic              en;
        logic              dbl;
        logic [TYPE_W-1:0] typ;
    } ep_lay_t;

    typedef struct packed {
        ep_lay_t [NUM_EP-1:0] ep;
        logic                 err;
    } lay_t;

    typedef struct packed {
        logic [1:0] full;
        logic       wr;
        logic       rd;
    } ep_flag_t;
endpackage

// File: rtl/ep_cfg_stage.sv
module ep_cfg_stage
    import ep_alloc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [EP_W-1:0]       cfg_ep,
    input  ep_cfg_t               cfg_word,
    output ep_cfg_t [NUM_EP-1:0]  stage_q
);
    ep_cfg_t [NUM_EP-1:0] stage_d;

    always_comb begin
        stage_d = stage_q;
        if (cfg_we && (cfg_ep >= EP_W'(NUM_CTRL))) begin
            stage_d[cfg_ep] = cfg_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/ep_layout.sv
module ep_layout
    import ep_alloc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  ep_cfg_t [NUM_EP-1:0]  stage,
    output lay_t                  lay_q
);
    lay_t calc;
    lay_t lay_d;

    always_comb begin
        logic [SUM_W-1:0] acc;
        logic [RSZ_W-1:0] r;
        acc  = '0;
        calc = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (i < NUM_CTRL) begin
                r = RSZ_W'(CTRL_BYTES);
                calc.ep[i].en  = 1'b1;
                calc.ep[i].dbl = 1'b0;
                calc.ep[i].typ = '0;
            end else begin
                r = ({1'b0, stage[i].size} + RSZ_W'(3)) & ~RSZ_W'(3);
                calc.ep[i].en  = stage[i].en;
                calc.ep[i].dbl = stage[i].dbl;
                calc.ep[i].typ = stage[i].typ;
            end
            calc.ep[i].rsz  = r;
            calc.ep[i].base = acc[ADDR_W-1:0];
            if (calc.ep[i].en) begin
                acc = acc + SUM_W'(r) + (calc.ep[i].dbl ? SUM_W'(r) : '0);
            end
        end
        calc.err = (acc > SUM_W'(MEM_BYTES));
    end

    always_comb begin
        lay_d = commit ? calc : lay_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lay_q <= '0;
        else        lay_q <= lay_d;
    end

    // R2: after any commit the first control endpoint sits at offset 0
    p_ctrl_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (lay_q.ep[0].base == '0) && lay_q.ep[0].en);
endmodule

// File: rtl/ep_flag_track.sv
module ep_flag_track
    import ep_alloc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  lay_t            lay,
    input  logic [EP_W-1:0] usb_ep,
    input  logic            usb_done,
    input  logic [EP_W-1:0] cpu_ep,
    input  logic            cpu_done,
    output logic            usb_half,
    output logic            cpu_half,
    output logic            usb_ready,
    output logic            cpu_avail
);
    ep_flag_t [NUM_EP-1:0] fl_d, fl_q;

    always_comb begin
        usb_half  = fl_q[usb_ep].wr;
        cpu_half  = fl_q[cpu_ep].rd;
        usb_ready = lay.ep[usb_ep].en && !lay.err && !fl_q[usb_ep].full[usb_half];
        cpu_avail = lay.ep[cpu_ep].en && !lay.err &&  fl_q[cpu_ep].full[cpu_half];

        fl_d = fl_q;
        if (commit) begin
            fl_d = '0;
        end else begin
            if (usb_done && usb_ready) begin
                fl_d[usb_ep].full[usb_half] = 1'b1;
                if (lay.ep[usb_ep].dbl) fl_d[usb_ep].wr = ~usb_half;
            end
            if (cpu_done && cpu_avail) begin
                fl_d[cpu_ep].full[cpu_half] = 1'b0;
                if (lay.ep[cpu_ep].dbl) fl_d[cpu_ep].rd = ~cpu_half;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    // R9: a refused fill with no drain and no commit leaves every flag as it was
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_done && !usb_ready && !cpu_done && !commit) |=> $stable(fl_q));

    // R6: a single-buffered fill makes the same endpoint not ready next cycle
    p_single_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_done && usb_ready && !lay.ep[usb_ep].dbl && !commit)
        |=> ($stable(usb_ep) -> !usb_ready));

    // R8: a single-buffered drain leaves nothing to read next cycle
    p_single_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_avail && !lay.ep[cpu_ep].dbl && !commit)
        |=> ($stable(cpu_ep) -> !cpu_avail));

    // R10: a commit leaves no half full
    p_commit_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !cpu_avail);
endmodule

// File: rtl/ep_buf_alloc.sv
module ep_buf_alloc
    import ep_alloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [EP_W-1:0]   cfg_ep,
    input  logic              cfg_en,
    input  logic              cfg_dbl,
    input  logic [TYPE_W-1:0] cfg_type,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              commit,
    input  logic [EP_W-1:0]   usb_ep,
    input  logic              usb_done,
    input  logic [EP_W-1:0]   cpu_ep,
    input  logic              cpu_done,
    output logic [ADDR_W-1:0] usb_ptr,
    output logic              usb_ready,
    output logic [TYPE_W-1:0] usb_type,
    output logic [ADDR_W-1:0] cpu_ptr,
    output logic              cpu_avail,
    output logic              alloc_err
);
    ep_cfg_t              cfg_word;
    ep_cfg_t [NUM_EP-1:0] stage;
    lay_t                 lay;
    logic                 usb_half, cpu_half;

    assign cfg_word = '{en: cfg_en, dbl: cfg_dbl, typ: cfg_type, size: cfg_size};

    ep_cfg_stage u_stage (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep),
        .cfg_word(cfg_word), .stage_q(stage)
    );

    ep_layout u_layout (
        .clk(clk), .rst_n(rst_n), .commit(commit), .stage(stage), .lay_q(lay)
    );

    ep_flag_track u_track (
        .clk(clk), .rst_n(rst_n), .commit(commit), .lay(lay),
        .usb_ep(usb_ep), .usb_done(usb_done), .cpu_ep(cpu_ep), .cpu_done(cpu_done),
        .usb_half(usb_half), .cpu_half(cpu_half),
        .usb_ready(usb_ready), .cpu_avail(cpu_avail)
    );

    always_comb begin
        usb_ptr   = lay.ep[usb_ep].base + (usb_half ? ADDR_W'(lay.ep[usb_ep].rsz) : '0);
        cpu_ptr   = lay.ep[cpu_ep].base + (cpu_half ? ADDR_W'(lay.ep[cpu_ep].rsz) : '0);
        usb_type  = lay.ep[usb_ep].typ;
        alloc_err = lay.err;
    end

    // R7: an accepted double-buffered fill moves the producer pointer
    p_dbl_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_done && usb_ready && lay.ep[usb_ep].dbl && (lay.ep[usb_ep].rsz != '0) && !commit)
        |=> ($stable(usb_ep) -> (usb_ptr != $past(usb_ptr))));
endmodule

// File: tb/ep_buf_alloc_bench.sv
module ep_buf_alloc_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_en, cfg_dbl, commit, usb_done, cpu_done;
    logic [3:0]  cfg_ep, usb_ep, cpu_ep;
    logic [1:0]  cfg_type;
    logic [10:0] cfg_size;
    logic [12:0] usb_ptr, cpu_ptr;
    logic        usb_ready, cpu_avail, alloc_err;
    logic [1:0]  usb_type;

    int checks = 0;
    int failures = 0;

    int s_en[16], s_dbl[16], s_typ[16], s_size[16];
    int c_base[16], c_rsz[16], c_en[16], c_dbl[16], c_typ[16];
    int c_err;
    int f_full[16][2], f_wr[16], f_rd[16];

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_buf_alloc u_ep_buf_alloc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_en(cfg_en),
        .cfg_dbl(cfg_dbl), .cfg_type(cfg_type), .cfg_size(cfg_size), .commit(commit),
        .usb_ep(usb_ep), .usb_done(usb_done), .cpu_ep(cpu_ep), .cpu_done(cpu_done),
        .usb_ptr(usb_ptr), .usb_ready(usb_ready), .usb_type(usb_type),
        .cpu_ptr(cpu_ptr), .cpu_avail(cpu_avail), .alloc_err(alloc_err)
    );

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd4(int s);
        return (s + 3) / 4 * 4;
    endfunction

    function automatic int m_ready(int e);
        return (c_en[e] != 0 && c_err == 0 && f_full[e][f_wr[e]] == 0) ? 1 : 0;
    endfunction

    function automatic int m_avail(int e);
        return (c_en[e] != 0 && c_err == 0 && f_full[e][f_rd[e]] != 0) ? 1 : 0;
    endfunction

    function automatic int m_ptr(int e, int half);
        return (c_base[e] + (half != 0 ? c_rsz[e] : 0)) % 8192;
    endfunction

    task automatic model_commit();
        int acc = 0;
        for (int i = 0; i < 16; i++) begin
            if (i < 2) begin
                c_rsz[i] = 64; c_en[i] = 1; c_dbl[i] = 0; c_typ[i] = 0;
            end else begin
                c_rsz[i] = rnd4(s_size[i]); c_en[i] = s_en[i];
                c_dbl[i] = s_dbl[i]; c_typ[i] = s_typ[i];
            end
            c_base[i] = acc % 8192;
            if (c_en[i] != 0) acc += (c_dbl[i] != 0) ? 2 * c_rsz[i] : c_rsz[i];
            f_full[i][0] = 0; f_full[i][1] = 0; f_wr[i] = 0; f_rd[i] = 0;
        end
        c_err = (acc > 8192) ? 1 : 0;
    endtask

    // one cycle: compare outputs with the model, then advance the model at the edge
    task automatic step();
        int ue, ce, ur, ca;
        #2;
        ue = int'(usb_ep); ce = int'(cpu_ep);
        ur = m_ready(ue); ca = m_avail(ce);
        expect_eq("R6 usb_ready", int'(usb_ready), ur);
        expect_eq("R8 cpu_avail", int'(cpu_avail), ca);
        expect_eq("R3 usb_ptr", int'(usb_ptr), m_ptr(ue, f_wr[ue]));
        expect_eq("R8 cpu_ptr", int'(cpu_ptr), m_ptr(ce, f_rd[ce]));
        expect_eq("R11 usb_type", int'(usb_type), c_typ[ue]);
        expect_eq("R5 alloc_err", int'(alloc_err), c_err);
        @(posedge clk);
        if (commit) begin
            model_commit();
        end else begin
            if (usb_done && ur != 0) begin
                f_full[ue][f_wr[ue]] = 1;
                if (c_dbl[ue] != 0) f_wr[ue] = 1 - f_wr[ue];
            end
            if (cpu_done && ca != 0) begin
                f_full[ce][f_rd[ce]] = 0;
                if (c_dbl[ce] != 0) f_rd[ce] = 1 - f_rd[ce];
            end
        end
        if (cfg_we && cfg_ep >= 2) begin
            s_en[cfg_ep] = cfg_en; s_dbl[cfg_ep] = cfg_dbl;
            s_typ[cfg_ep] = cfg_type; s_size[cfg_ep] = cfg_size;
        end
        @(negedge clk);
    endtask

    task automatic cfg(int e, int en, int dbl, int typ, int size);
        cfg_ep = 4'(e); cfg_en = 1'(en); cfg_dbl = 1'(dbl);
        cfg_type = 2'(typ); cfg_size = 11'(size); cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1; step(); commit = 1'b0;
    endtask

    task automatic strobe(int ue, int ud, int ce, int cd);
        usb_ep = 4'(ue); cpu_ep = 4'(ce); usb_done = 1'(ud); cpu_done = 1'(cd);
        step();
        usb_done = 1'b0; cpu_done = 1'b0;
    endtask

    // select endpoints and settle; no strobes, so the state does not move
    task automatic peek(int ue, int ce);
        usb_ep = 4'(ue); cpu_ep = 4'(ce);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        rst_n = 1'b0; cfg_we = 0; cfg_ep = 0; cfg_en = 0; cfg_dbl = 0; cfg_type = 0;
        cfg_size = 0; commit = 0; usb_ep = 0; usb_done = 0; cpu_ep = 0; cpu_done = 0;
        for (int i = 0; i < 16; i++) begin
            s_en[i] = 0; s_dbl[i] = 0; s_typ[i] = 0; s_size[i] = 0;
            c_base[i] = 0; c_rsz[i] = 0; c_en[i] = 0; c_dbl[i] = 0; c_typ[i] = 0;
            f_full[i][0] = 0; f_full[i][1] = 0; f_wr[i] = 0; f_rd[i] = 0;
        end
        c_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle before any commit, strobes refused
        peek(0, 0);
        expect_eq("R1 usb_ready", int'(usb_ready), 0);
        expect_eq("R1 alloc_err", int'(alloc_err), 0);
        strobe(0, 1, 0, 0);
        peek(0, 0);
        expect_eq("R1 cpu_avail", int'(cpu_avail), 0);
        @(negedge clk);

        // layout: ep0 write ignored, ep3 size 10 doubled, ep4 disabled
        cfg(0, 1, 1, 3, 999);
        cfg(2, 1, 0, 1, 64);
        cfg(3, 1, 1, 3, 10);
        cfg(4, 0, 0, 2, 100);
        cfg(5, 1, 1, 2, 512);
        do_commit();
        peek(0, 1);
        expect_eq("R2 ep0 base", int'(usb_ptr), 0);
        expect_eq("R2 ep1 base", int'(cpu_ptr), 64);
        expect_eq("R11 ep0 type", int'(usb_type), 0);
        @(negedge clk);
        peek(2, 3);
        expect_eq("R3 ep2 base", int'(usb_ptr), 128);
        expect_eq("R11 ep2 type", int'(usb_type), 1);
        expect_eq("R3 ep3 base", int'(cpu_ptr), 192);
        @(negedge clk);
        peek(5, 4);
        expect_eq("R4 ep5 base", int'(usb_ptr), 216);
        expect_eq("R11 ep5 type", int'(usb_type), 2);
        expect_eq("R3 ep4 disabled avail", int'(cpu_avail), 0);
        @(negedge clk);
        peek(4, 4);
        expect_eq("R3 ep4 disabled ready", int'(usb_ready), 0);
        @(negedge clk);

        // R7: double buffer alternates
        strobe(3, 1, 3, 0);
        peek(3, 3);
        expect_eq("R7 ep3 second half ptr", int'(usb_ptr), 204);
        expect_eq("R7 ep3 still ready", int'(usb_ready), 1);
        expect_eq("R6 ep3 avail", int'(cpu_avail), 1);
        expect_eq("R8 ep3 cpu ptr", int'(cpu_ptr), 192);
        @(negedge clk);
        strobe(3, 1, 3, 0);
        peek(3, 3);
        expect_eq("R7 ep3 both full", int'(usb_ready), 0);
        @(negedge clk);
        strobe(3, 1, 3, 0);  // refused fill
        peek(3, 3);
        expect_eq("R9 ep3 ptr kept", int'(usb_ptr), 192);
        @(negedge clk);
        strobe(3, 0, 3, 1);
        peek(3, 3);
        expect_eq("R8 ep3 cpu moves", int'(cpu_ptr), 204);
        expect_eq("R8 ep3 ready again", int'(usb_ready), 1);
        @(negedge clk);

        // R6: single buffer
        strobe(2, 1, 2, 0);
        peek(2, 2);
        expect_eq("R6 ep2 full", int'(usb_ready), 0);
        expect_eq("R6 ep2 avail", int'(cpu_avail), 1);
        @(negedge clk);
        strobe(4, 1, 4, 0);
        peek(4, 4);
        expect_eq("R9 ep4 disabled fill", int'(cpu_avail), 0);
        @(negedge clk);

        // R12: fill and drain together on ep5
        strobe(5, 1, 5, 0);
        strobe(5, 1, 5, 1);
        peek(5, 5);
        expect_eq("R12 ep5 usb ptr", int'(usb_ptr), 216);
        expect_eq("R12 ep5 ready", int'(usb_ready), 1);
        expect_eq("R12 ep5 cpu ptr", int'(cpu_ptr), 728);
        expect_eq("R12 ep5 avail", int'(cpu_avail), 1);
        @(negedge clk);

        // R10: commit clears, staging needs commit
        do_commit();
        peek(3, 5);
        expect_eq("R10 cleared", int'(cpu_avail), 0);
        expect_eq("R10 ep3 base", int'(usb_ptr), 192);
        @(negedge clk);
        cfg(2, 1, 0, 1, 100);
        peek(3, 3);
        expect_eq("R10 staged not live", int'(usb_ptr), 192);
        @(negedge clk);
        do_commit();
        peek(3, 3);
        expect_eq("R10 after commit", int'(usb_ptr), 228);
        @(negedge clk);

        // R5: exact fit then overflow by 4 bytes
        cfg(2, 1, 1, 0, 2032);
        cfg(3, 1, 1, 0, 2000);
        cfg(4, 0, 0, 0, 0);
        cfg(5, 0, 0, 0, 0);
        do_commit();
        peek(2, 2);
        expect_eq("R5 exact fit", int'(alloc_err), 0);
        expect_eq("R5 exact fit ready", int'(usb_ready), 1);
        @(negedge clk);
        cfg(4, 1, 0, 0, 1);
        do_commit();
        peek(2, 2);
        expect_eq("R5 overflow", int'(alloc_err), 1);
        expect_eq("R5 blocked", int'(usb_ready), 0);
        @(negedge clk);
        strobe(2, 1, 2, 0);
        peek(2, 2);
        expect_eq("R5 strobe ignored", int'(cpu_avail), 0);
        @(negedge clk);

        // random phase
        for (int r = 0; r < 20; r++) begin
            for (int e = 2; e < 16; e++) begin
                cfg(e, ($urandom % 10) < 7, $urandom % 2, $urandom % 4,
                    (r % 5 == 4) ? ($urandom % 2048) : ($urandom % 400));
            end
            do_commit();
            for (int k = 0; k < 150; k++) begin
                int ue = $urandom % 16;
                usb_ep = 4'(ue);
                cpu_ep = ($urandom % 2 == 0) ? 4'(ue) : 4'($urandom % 16);
                usb_done = 1'(($urandom % 10) < 6);
                cpu_done = 1'(($urandom % 10) < 6);
                commit = 1'(($urandom % 50) == 0);
                cfg_we = 1'(($urandom % 20) == 0);
                cfg_ep = 4'($urandom % 16); cfg_en = 1'($urandom % 2);
                cfg_dbl = 1'($urandom % 2); cfg_type = 2'($urandom % 4);
                cfg_size = 11'($urandom % 300);
                step();
            end
            usb_done = 0; cpu_done = 0; commit = 0; cfg_we = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule